// File: doc/BRIEF.md
# Conversion Mode Sequencer

This block decides when an attached sampling converter runs. A host selects between a free-running mode, in which conversions follow one another without pause, and a one-shot mode, in which the block sits powered down until the host requests a single conversion. A single start/busy bit has two jobs. Writing it launches a one-shot conversion, and reading it shows whether the sequencer is still working.

On the converter side, the block issues a one-cycle start pulse and waits for a done pulse that carries the result word. It captures the result into an output register. It drives a power-down output that is high only while the block is idle. A change from free-running to one-shot mode does not abort the conversion in flight. That conversion completes, its result is stored, and only then does the block power down. A synchronous reset restores the default configuration, which is free-running mode with a conversion launched right away.

States: `ST_IDLE` is powered down and waiting. `ST_LAUNCH` issues the start pulse for one cycle. `ST_CONVERT` waits for done. The transitions are:
- reset to `ST_LAUNCH`;
- `ST_IDLE` to `ST_LAUNCH` on a start request or on selection of free-running mode;
- `ST_LAUNCH` to `ST_CONVERT` always;
- `ST_CONVERT` to `ST_LAUNCH` on done in free-running mode;
- `ST_CONVERT` to `ST_IDLE` on done in one-shot mode.

Top module: `conv_mode_seq`

## Requirements
- R1: In free-running mode (`cfg_cont`=1), a done pulse during a conversion stores `conv_data` into `result`, and `conv_start` is high in the very next cycle.
- R2: While free-running mode is selected, `busy_rd` reads 1 in every cycle.
- R3: In one-shot mode (`cfg_cont`=0) and idle, `pwr_down` is 1 and `conv_start` stays 0. A write with `cfg_start`=1 makes `conv_start` high and `pwr_down` 0 in the next cycle. `conv_start` is always a single-cycle pulse.
- R4: When a one-shot conversion's done pulse arrives, the following cycle shows the new `result`, `busy_rd`=0 and `pwr_down`=1.
- R5: A write with `cfg_start`=1 while a conversion is running has no effect: no extra conversion follows, and the block goes idle after the running one.
- R6: A switch from free-running to one-shot mode during a conversion keeps `busy_rd`=1 and `pwr_down`=0 until that conversion's done pulse. After done, the result is stored, `busy_rd` is 0, `pwr_down` is 1, and no new start follows.
- R7: Synchronous reset (`rst`=1) restores free-running mode. In the first cycle after reset `conv_start`=1, `busy_rd`=1, `pwr_down`=0 and `result`=0.
- R8: `result` changes only in the cycle after a done pulse that arrives during a running conversion. A done pulse while idle leaves it unchanged.
- R9: In one-shot idle, a write with `cfg_start`=0 changes nothing: `pwr_down` stays 1, `busy_rd` stays 0, and no start is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cont | input | 1 | Mode bit written: 1 free-running, 0 one-shot |
| cfg_start | input | 1 | Start/busy bit written: 1 requests a one-shot conversion |
| busy_rd | output | 1 | Start/busy readback: 1 while busy or free-running |
| conv_start | output | 1 | One-cycle start pulse to the converter |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | DATA_W | Converter result, valid with `conv_done` |
| result | output | DATA_W | Output register holding the last result |
| pwr_down | output | 1 | Power-down request to the converter |

## Verification
The checker assumes the converter raises `conv_done` for one cycle per conversion, and only after a start pulse. It also assumes a mode write on the same edge as done is the only way the next state can differ from the registered mode, so its completion properties exclude that edge. The bench's converter model raises done only while a conversion is pending. It places every host write on a different edge from a done pulse, except where a scenario deliberately probes done in idle, which the properties treat as a don't-care.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_LAUNCH  = 2'd1,
        ST_CONVERT = 2'd2
    } seq_state_t;

    localparam logic MODE_CONT_DEFAULT = 1'b1;

endpackage

// File: rtl/conv_cfg_reg.sv
module conv_cfg_reg (
    input  logic clk,
    input  logic rst,
    input  logic cfg_we,
    input  logic cfg_cont,
    input  logic cfg_start,
    output logic mode_q,
    output logic mode_next,
    output logic start_req
);
    import conv_seq_pkg::*;

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= MODE_CONT_DEFAULT;
        else if (cfg_we)
            mode_q <= cfg_cont;
    end

    // Mode as it will stand after this edge; lets a same-edge write steer the FSM.
    assign mode_next = cfg_we ? cfg_cont : mode_q;
    assign start_req = cfg_we & cfg_start;

endmodule

// File: rtl/conv_seq_fsm.sv
module conv_seq_fsm (
    input  logic clk,
    input  logic rst,
    input  logic mode_next,
    input  logic start_req,
    input  logic conv_done,
    output logic conv_start,
    output logic pwr_down,
    output logic active,
    output logic capture
);
    import conv_seq_pkg::*;

    seq_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_LAUNCH;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (mode_next || start_req)
                    state_d = ST_LAUNCH;
            end
            ST_LAUNCH: begin
                state_d = ST_CONVERT;
            end
            ST_CONVERT: begin
                if (conv_done)
                    state_d = mode_next ? ST_LAUNCH : ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        conv_start = 1'b0;
        pwr_down   = 1'b0;
        active     = 1'b1;
        capture    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                pwr_down = 1'b1;
                active   = 1'b0;
            end
            ST_LAUNCH: begin
                conv_start = 1'b1;
            end
            ST_CONVERT: begin
                capture = conv_done;
            end
            default: begin
                pwr_down = 1'b1;
                active   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/conv_result_reg.sv
module conv_result_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] result
);
    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (capture)
            result <= conv_data;
    end

endmodule

// File: rtl/conv_mode_seq.sv
module conv_mode_seq #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_cont,
    input  logic              cfg_start,
    output logic              busy_rd,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] result,
    output logic              pwr_down
);
    logic mode_q, mode_next, start_req;
    logic active, capture;

    conv_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_cont  (cfg_cont),
        .cfg_start (cfg_start),
        .mode_q    (mode_q),
        .mode_next (mode_next),
        .start_req (start_req)
    );

    conv_seq_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .mode_next  (mode_next),
        .start_req  (start_req),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .pwr_down   (pwr_down),
        .active     (active),
        .capture    (capture)
    );

    conv_result_reg #(.DATA_W(DATA_W)) u_res (
        .clk       (clk),
        .rst       (rst),
        .capture   (capture),
        .conv_data (conv_data),
        .result    (result)
    );

    // Free-running mode always reads busy; otherwise busy tracks a conversion in flight.
    assign busy_rd = mode_q | active;

endmodule

// File: rtl/conv_mode_seq_chk.sv
module conv_mode_seq_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              cfg_cont,
    input logic              mode_q,
    input logic              busy_rd,
    input logic              conv_start,
    input logic              conv_done,
    input logic              pwr_down,
    input logic [DATA_W-1:0] result
);
    AST_CONT_BUSY: assert property (@(posedge clk) disable iff (rst)
        mode_q |-> busy_rd);  // R2

    AST_CONT_RESTART: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !(cfg_we && !cfg_cont) && conv_done && !pwr_down && !conv_start)
        |=> conv_start);  // R1

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start);  // R3

    AST_PD_NO_START: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (!conv_start && !busy_rd));  // R3

    AST_SINGLE_DONE: assert property (@(posedge clk) disable iff (rst)
        (!mode_q && !(cfg_we && cfg_cont) && conv_done && busy_rd && !conv_start)
        |=> (pwr_down && !busy_rd));  // R4

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !conv_done |=> $stable(result));  // R8

endmodule

bind conv_mode_seq conv_mode_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_cont   (cfg_cont),
    .mode_q     (mode_q),
    .busy_rd    (busy_rd),
    .conv_start (conv_start),
    .conv_done  (conv_done),
    .pwr_down   (pwr_down),
    .result     (result)
);

// File: tb/conv_mode_seq_test.sv
module conv_mode_seq_test;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0, cfg_cont = 1'b0, cfg_start = 1'b0;
    logic          conv_done = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          busy_rd, conv_start, pwr_down;
    logic [DW-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    conv_mode_seq #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cont(cfg_cont),
        .cfg_start(cfg_start), .busy_rd(busy_rd), .conv_start(conv_start),
        .conv_done(conv_done), .conv_data(conv_data), .result(result),
        .pwr_down(pwr_down)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(input logic cont, input logic start);
        cfg_we = 1'b1; cfg_cont = cont; cfg_start = start;
        step();
        cfg_we = 1'b0; cfg_start = 1'b0;
    endtask

    task automatic finish_conv(input logic [DW-1:0] d);
        conv_data = d; conv_done = 1'b1;
        step();
        conv_done = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        rst = 1'b0;
        chk("R7", "conv_start", conv_start, 1);
        chk("R7", "busy_rd", busy_rd, 1);
        chk("R7", "pwr_down", pwr_down, 0);
        chk("R7", "result", result, 0);
    endtask

    task automatic t_continuous();
        step();
        chk("R2", "busy_rd converting", busy_rd, 1);
        chk("R3", "start pulse width", conv_start, 0);
        finish_conv(16'h1234);
        chk("R1", "result", result, 16'h1234);
        chk("R1", "restart", conv_start, 1);
        chk("R2", "busy_rd launch", busy_rd, 1);
        step();
        finish_conv(16'hBEEF);
        chk("R1", "result second", result, 16'hBEEF);
        chk("R1", "restart second", conv_start, 1);
        step();
    endtask

    task automatic t_switch_midway();
        wr(1'b0, 1'b0);
        chk("R6", "busy_rd after switch", busy_rd, 1);
        chk("R6", "pwr_down after switch", pwr_down, 0);
        finish_conv(16'h0F0F);
        chk("R6", "result", result, 16'h0F0F);
        chk("R6", "busy_rd", busy_rd, 0);
        chk("R6", "pwr_down", pwr_down, 1);
        chk("R6", "conv_start", conv_start, 0);
        repeat (3) step();
        chk("R6", "no restart", conv_start, 0);
    endtask

    task automatic t_idle_ignores();
        wr(1'b0, 1'b0);
        chk("R9", "pwr_down", pwr_down, 1);
        chk("R9", "busy_rd", busy_rd, 0);
        chk("R9", "conv_start", conv_start, 0);
        finish_conv(16'hDEAD);
        chk("R8", "result after idle done", result, 16'h0F0F);
        chk("R8", "conv_start after idle done", conv_start, 0);
    endtask

    task automatic t_single_shot();
        wr(1'b0, 1'b1);
        chk("R3", "conv_start", conv_start, 1);
        chk("R3", "pwr_down", pwr_down, 0);
        chk("R3", "busy_rd", busy_rd, 1);
        step();
        wr(1'b0, 1'b1);
        chk("R5", "conv_start after busy write", conv_start, 0);
        chk("R5", "busy_rd", busy_rd, 1);
        finish_conv(16'h5A5A);
        chk("R4", "result", result, 16'h5A5A);
        chk("R4", "busy_rd", busy_rd, 0);
        chk("R4", "pwr_down", pwr_down, 1);
        repeat (2) step();
        chk("R5", "no second conversion", conv_start, 0);
        chk("R5", "still powered down", pwr_down, 1);
    endtask

    task automatic t_reset_config();
        rst = 1'b1;
        step();
        rst = 1'b0;
        chk("R7", "conv_start after reset", conv_start, 1);
        chk("R7", "busy_rd after reset", busy_rd, 1);
        chk("R7", "result after reset", result, 0);
        step();
        finish_conv(16'h0007);
        chk("R7", "free-running default restart", conv_start, 1);
        step();
    endtask

    task automatic t_idle_to_cont();
        wr(1'b0, 1'b0);
        finish_conv(16'h0001);
        chk("R4", "idle before mode change", pwr_down, 1);
        wr(1'b1, 1'b0);
        chk("R1", "start on free-running select", conv_start, 1);
        chk("R2", "busy_rd on free-running select", busy_rd, 1);
    endtask

    initial begin
        t_reset();
        t_continuous();
        t_switch_midway();
        t_idle_ignores();
        t_single_shot();
        t_reset_config();
        t_idle_to_cont();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule